// File: doc/BRIEF.md
# Converter configuration register loader

This block receives a one-byte configuration word for a data converter over three serial pins: an active-low conversion-start line, a serial clock and a serial data input. All three pins are sampled by a faster system clock through a two-stage synchronizer. Edges are detected in the system clock domain.

A load is opened by a particular entry condition: the conversion-start line falls while the serial clock is high. The block then takes the data pin on each of the next eight falling serial clock edges, most significant bit first. The captured byte is written to the configuration register only when the conversion-start line returns high. A load that ends early leaves the register as it was.

The register fields drive four outputs:
- the chaining mode,
- the busy-indication enable,
- the two-bit reference mode,
- the shutdown control.

The system clock must be fast enough that every serial clock level lasts several system clock cycles.

Top module: `conv_cfg_loader`

## Requirements
- R1: While `rst_n` is low, and after it is released, the register holds 0x00. All decoded outputs are 0: chip-select mode, no busy indicator, reference mode 0, normal power.
- R2: A load opens only when `conv_start_n` falls while `ser_clk` is high. A fall with `ser_clk` low opens nothing, and the serial clock edges that follow it leave the register unchanged.
- R3: In an open load, `ser_din` is taken on each of the first eight falling edges of `ser_clk`. The first bit taken lands in bit 7 and the last in bit 0.
- R4: The register does not change while `conv_start_n` is still low. A complete byte becomes visible on `cfg_word` within three system clock cycles after `conv_start_n` rises, as seen by the synchronizer.
- R5: If `conv_start_n` rises after fewer than eight bits have been taken, the load is dropped and the register keeps its previous value.
- R6: Falling `ser_clk` edges after the eighth bit, and before `conv_start_n` rises, do not alter the byte that is committed.
- R7: `daisy_chain` equals register bit 7 (1 = daisy-chain mode, 0 = chip-select mode). `busy_flag_en` equals register bit 6 (1 = busy indicator on).
- R8: `ref_mode` equals register bits 5:4. The values mean:
  - 0: internal reference and buffer both on.
  - 1: reference off, buffer on.
  - 2: reference on, buffer off.
  - 3: both off.
- R9: `shutdown` equals register bit 3 (1 = static shutdown, 0 = normal). Bits 2:0 are reserved; they are stored as received and drive nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start_n | input | 1 | Conversion-start line, asynchronous, idles high |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_din | input | 1 | Serial data, asynchronous, idles high |
| cfg_word | output | 8 | Committed configuration byte |
| daisy_chain | output | 1 | Chaining mode select (register bit 7) |
| busy_flag_en | output | 1 | Busy indicator enable (register bit 6) |
| ref_mode | output | 2 | Reference mode select (register bits 5:4) |
| shutdown | output | 1 | Static shutdown request (register bit 3) |

## Verification
A wrong internal state always shows up as a wrong committed byte. It appears on `cfg_word` and the decoded outputs within three system cycles of the conversion-start rise, and never before that rise.

Some faults are caught by comparing the register just before and just after each rise:
- A miscounted bit counter either commits a truncated load or drops a full one.
- A bad shift direction reverses the byte.
- A false arm after a fall with the serial clock low commits a byte that should have been discarded.

An extra edge that is wrongly accepted after the eighth bit moves every bit up by one, so the committed byte differs from the expected one.

// File: rtl/cfgld_pkg.sv
// Package: shared state type and register field positions for the
// configuration loader. Assumes an 8-bit configuration word.
package cfgld_pkg;
    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_SHIFT = 1'b1
    } ld_state_t;

    localparam int FLD_CHAIN = 7;
    localparam int FLD_BUSY = 6;
    localparam int FLD_REF_HI = 5;
    localparam int FLD_REF_LO = 4;
    localparam int FLD_SHDN = 3;
endpackage

// File: rtl/cfgld_sync.sv
// Module: multi-bit level synchronizer. Each bit passes through STAGES
// flops. Assumes the bits are independent levels. The reset value per bit
// is given by RST_VAL, so that idle pins read as idle right after reset.
module cfgld_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        // Shift the pin value through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/cfgld_edge.sv
// Module: edge detector for a signal that is already synchronized.
// Assumes the input is clean in the clk domain. Each output pulses for one
// cycle, the cycle after the level change is seen.
module cfgld_edge #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/cfgld_shifter.sv
// Module: load sequencer and shift register. It arms on a start fall with
// the serial clock high, and shifts on serial clock falls (MSB first) up to
// CFG_BITS bits. It raises commit_o on the start rise only if the byte is
// complete. Assumes edge pulses are single-cycle.
module cfgld_shifter
    import cfgld_pkg::*;
#(
    parameter int CFG_BITS = 8,
    localparam int CW = $clog2(CFG_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_fall_i,
    input  logic                start_rise_i,
    input  logic                sclk_fall_i,
    input  logic                sclk_lvl_i,
    input  logic                din_lvl_i,
    output logic                commit_o,
    output logic [CFG_BITS-1:0] shift_o,
    output ld_state_t           state_o,
    output logic [CW-1:0]       count_o
);
    ld_state_t            state_q;
    logic [CW-1:0]        cnt_q;
    logic [CFG_BITS-1:0]  sh_q;
    logic                 full;

    assign full = (cnt_q == CW'(CFG_BITS));

    // Sequence a load: arm, count bits taken, close on the start rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                LD_IDLE: if (start_fall_i && sclk_lvl_i) begin
                    state_q <= LD_SHIFT;
                    cnt_q   <= '0;
                end
                LD_SHIFT: if (start_rise_i) begin
                    state_q <= LD_IDLE;
                end else if (sclk_fall_i && !full) begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: state_q <= LD_IDLE;
            endcase
        end
    end

    // Shift the data bit in at the LSB on each accepted serial clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else if (state_q == LD_SHIFT && !start_rise_i && sclk_fall_i && !full)
            sh_q <= {sh_q[CFG_BITS-2:0], din_lvl_i};
    end

    assign commit_o = (state_q == LD_SHIFT) && start_rise_i && full;
    assign shift_o  = sh_q;
    assign state_o  = state_q;
    assign count_o  = cnt_q;
endmodule

// File: rtl/conv_cfg_loader.sv
// Module: top of the configuration loader. It synchronizes the three serial
// pins, detects edges, runs the sequencer and holds the committed register
// with its field decode. Assumes clk is several times faster than ser_clk.
module conv_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int CFG_BITS = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CW = $clog2(CFG_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_start_n,
    input  logic                ser_clk,
    input  logic                ser_din,
    output logic [CFG_BITS-1:0] cfg_word,
    output logic                daisy_chain,
    output logic                busy_flag_en,
    output logic [1:0]          ref_mode,
    output logic                shutdown
);
    logic [2:0]          pins_s;
    logic                start_s, sclk_s, din_s;
    logic                start_rise, start_fall, sclk_rise, sclk_fall;
    logic                commit;
    logic [CFG_BITS-1:0] shift_val;
    ld_state_t           ld_state;
    logic [CW-1:0]       bit_count;
    logic [CFG_BITS-1:0] cfg_q;

    cfgld_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({conv_start_n, ser_clk, ser_din}),
        .sync_o(pins_s)
    );
    assign {start_s, sclk_s, din_s} = pins_s;

    cfgld_edge #(.RST_VAL(1'b1)) u_start_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(start_s),
        .rise_o(start_rise), .fall_o(start_fall)
    );

    cfgld_edge #(.RST_VAL(1'b1)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(sclk_s),
        .rise_o(sclk_rise), .fall_o(sclk_fall)
    );

    cfgld_shifter #(.CFG_BITS(CFG_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start_fall_i(start_fall), .start_rise_i(start_rise),
        .sclk_fall_i(sclk_fall), .sclk_lvl_i(sclk_s), .din_lvl_i(din_s),
        .commit_o(commit), .shift_o(shift_val),
        .state_o(ld_state), .count_o(bit_count)
    );

    // Commit the completed byte into the configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (commit) cfg_q <= shift_val;
    end

    assign cfg_word     = cfg_q;
    assign daisy_chain  = cfg_q[FLD_CHAIN];
    assign busy_flag_en = cfg_q[FLD_BUSY];
    assign ref_mode     = cfg_q[FLD_REF_HI:FLD_REF_LO];
    assign shutdown     = cfg_q[FLD_SHDN];

    logic unused_rise;
    assign unused_rise = sclk_rise;
endmodule

// File: rtl/conv_cfg_loader_chk.sv
// Module: assertion checker for conv_cfg_loader, attached by bind.
// Assumes the default CFG_BITS.
module conv_cfg_loader_chk
    import cfgld_pkg::*;
#(
    parameter int CFG_BITS = 8,
    localparam int CW = $clog2(CFG_BITS + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CFG_BITS-1:0] cfg_word,
    input logic                start_rise,
    input logic                start_fall,
    input logic                sclk_s,
    input ld_state_t           ld_state,
    input logic [CW-1:0]       bit_count
);
    // R1: reset forces the register to zero.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> cfg_word == '0);

    // R2: a start fall with the serial clock low leaves the sequencer idle.
    a_r2_no_arm_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_state == LD_IDLE && start_fall && !sclk_s) |=> ld_state == LD_IDLE);

    // R4: the register only changes right after a start rise.
    a_r4_commit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(cfg_word)) |-> $past(start_rise));

    // R5: the register only changes after a full byte.
    a_r5_full_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(cfg_word)) |-> $past(bit_count) == CW'(CFG_BITS));

    // R6: the bit counter never passes the byte length.
    a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        bit_count <= CW'(CFG_BITS));
endmodule

bind conv_cfg_loader conv_cfg_loader_chk #(.CFG_BITS(CFG_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .start_rise(start_rise), .start_fall(start_fall), .sclk_s(sclk_s),
    .ld_state(ld_state), .bit_count(bit_count)
);

// File: tb/conv_cfg_loader_test.sv
// Bench: a vector table of serial loads, then directed reset cases.
module conv_cfg_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 4;      // system cycles per pin change
    localparam int NVEC = 7;

    // Vector fields: {byte[7:0], nbits[3:0], arm, extra[1:0], expected[7:0]}.
    localparam logic [22:0] VEC [NVEC] = '{
        {8'h68, 4'd8, 1'b1, 2'd0, 8'h68},   // full load
        {8'hC0, 4'd8, 1'b0, 2'd0, 8'h68},   // R2: armed with sclk low
        {8'hD8, 4'd5, 1'b1, 2'd0, 8'h68},   // R5: short load
        {8'hB0, 4'd8, 1'b1, 2'd3, 8'hB0},   // R6: extra edges
        {8'h18, 4'd8, 1'b1, 2'd0, 8'h18},
        {8'h00, 4'd8, 1'b1, 2'd1, 8'h00},
        {8'hF8, 4'd8, 1'b1, 2'd0, 8'hF8}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start_n = 1'b1;
    logic ser_clk = 1'b1;
    logic ser_din = 1'b1;
    logic [7:0] cfg_word;
    logic daisy_chain, busy_flag_en, shutdown;
    logic [1:0] ref_mode;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    conv_cfg_loader uut (
        .clk(clk), .rst_n(rst_n), .conv_start_n(conv_start_n),
        .ser_clk(ser_clk), .ser_din(ser_din), .cfg_word(cfg_word),
        .daisy_chain(daisy_chain), .busy_flag_en(busy_flag_en),
        .ref_mode(ref_mode), .shutdown(shutdown)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_all(input string tag, input logic [7:0] exp);
        chk({tag, " R4 cfg_word"}, cfg_word, exp);
        chk({tag, " R7 daisy_chain"}, {7'd0, daisy_chain}, {7'd0, exp[7]});
        chk({tag, " R7 busy_flag_en"}, {7'd0, busy_flag_en}, {7'd0, exp[6]});
        chk({tag, " R8 ref_mode"}, {6'd0, ref_mode}, {6'd0, exp[5:4]});
        chk({tag, " R9 shutdown"}, {7'd0, shutdown}, {7'd0, exp[3]});
    endtask

    // Open a load, clock out nbits+extra bits, then close it.
    task automatic load(input logic [7:0] b, input int nbits, input bit arm,
                        input int extra, input logic [7:0] prev);
        ser_clk = arm; ser_din = 1'b1; settle(HOLD);
        conv_start_n = 1'b0; settle(HOLD);
        if (!arm) begin ser_clk = 1'b1; settle(HOLD); end
        for (int i = 0; i < nbits + extra; i++) begin
            ser_din = (i < 8) ? b[7 - i] : 1'b0; settle(HOLD);
            ser_clk = 1'b0; settle(HOLD);
            ser_clk = 1'b1; settle(HOLD);
        end
        chk("R4 before rise", cfg_word, prev);
        conv_start_n = 1'b1;
        settle(5);
        ser_din = 1'b1;
        settle(HOLD);
    endtask

    initial begin
        logic [7:0] prev;
        settle(3);
        check_all("R1 reset", 8'h00);
        rst_n = 1'b1;
        settle(4);
        chk("R1 after release", cfg_word, 8'h00);
        prev = 8'h00;

        for (int v = 0; v < NVEC; v++) begin
            load(VEC[v][22:15], int'(VEC[v][14:11]), VEC[v][10],
                 int'(VEC[v][9:8]), prev);
            check_all($sformatf("R3 vec%0d", v), VEC[v][7:0]);
            prev = VEC[v][7:0];
        end

        // R1: reset in the middle of a load clears the register.
        ser_clk = 1'b1; settle(HOLD);
        conv_start_n = 1'b0; settle(HOLD);
        for (int i = 0; i < 4; i++) begin
            ser_clk = 1'b0; settle(HOLD);
            ser_clk = 1'b1; settle(HOLD);
        end
        rst_n = 1'b0; settle(3);
        check_all("R1 mid-load reset", 8'h00);
        rst_n = 1'b1; settle(HOLD);
        conv_start_n = 1'b1; settle(6);
        chk("R5 no bits after reset", cfg_word, 8'h00);

        // R8 and R9: remaining reference modes and shutdown.
        load(8'h28, 8, 1'b1, 0, 8'h00);
        check_all("R8 ref2", 8'h28);
        load(8'h5F, 8, 1'b1, 0, 8'h28);
        check_all("R9 reserved stored", 8'h5F);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule